// File: doc/BRIEF.md
# Streaming Ordered-Dither Halftoner

This block turns a stream of 8-bit grayscale samples into a stream of two-level samples for printing or display. Each sample is compared against one entry of a short threshold pattern, and the pattern entry moves forward by one for every accepted sample. A sample that lies strictly above its threshold comes out as full white (255). Any other sample comes out as full black (0). The pattern is set through a parameter when the block is built. By default it holds four entries, 32, 160, 224 and 96, which are eighths of full scale (1/8, 5/8, 7/8, 3/8). After the last entry the pattern starts again at the first.

Both sides of the block use valid/ready handshakes. A single output register holds the result of an accepted sample, so a result appears one cycle after its sample is accepted. Backpressure from the consumer freezes that register and closes the input. A synchronous restart input sends the pattern position back to entry 0, for example at the start of each image line.

Top module: `halftone_dither`

## Requirements
- R1: While and right after reset, out_valid is 0 and in_ready is 1, and the first sample accepted after reset is compared against pattern entry 0.
- R2: A sample strictly greater than its threshold gives out_pix = 255. A sample less than or equal to its threshold gives out_pix = 0. The comparison is unsigned.
- R3: Pattern entries 0, 1, 2 and 3 hold the thresholds 32, 160, 224 and 96.
- R4: Each accepted sample (in_valid and in_ready both 1) moves the pattern position forward by one. Entry 3 is followed by entry 0.
- R5: The pattern position does not change in a cycle in which no sample is accepted and restart is 0.
- R6: restart = 1 sets the pattern position to entry 0. A sample accepted in the same cycle as restart uses entry 0, and the next accepted sample uses entry 1.
- R7: A result is presented on out_valid/out_pix in the cycle after its sample is accepted. Results leave in the order their samples were accepted.
- R8: While out_valid = 1 and out_ready = 0, out_valid stays 1, out_pix does not change, and in_ready is 0.
- R9: in_ready is 1 whenever the output register is empty or is being emptied in the same cycle. This allows one sample per cycle under a ready consumer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous rewind of the pattern position to entry 0 |
| in_valid | input | 1 | Input sample present |
| in_pix | input | 8 | Grayscale input sample, unsigned |
| in_ready | output | 1 | Block can take a sample this cycle |
| out_valid | output | 1 | Result present |
| out_pix | output | 8 | Two-level result, 0 or 255 |
| out_ready | input | 1 | Consumer takes the result this cycle |

## Verification
A result is due exactly one clock after its sample is accepted, and it is held for as long as the consumer stalls. The pattern position changes only at an acceptance or a restart, and the change is visible from the following cycle. The bench drives its inputs just after the falling edge and lets the combinational ready settle. It then decides for itself whether a sample was accepted and whether a result was taken in that cycle. Expected results go into a first-in first-out list, and each one is compared when the handshake on the output side completes. out_valid and in_ready are compared against the fill state the bench has predicted for that cycle.

// File: rtl/dither_pkg.sv
package dither_pkg;

  // Two-level decision: strictly above the threshold means white.
  function automatic logic is_above(input logic [31:0] pix, input logic [31:0] thr);
    return pix > thr;
  endfunction

  // Position that follows pos in a pattern of len entries.
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/dither_index.sv
module dither_index #(
  parameter int unsigned PERIOD = 4,
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [IDX_W-1:0] use_idx,
  output logic [IDX_W-1:0] idx_q
);
  import dither_pkg::*;

  logic [IDX_W-1:0] idx_d;

  // Restart takes effect on the sample taken in the same cycle.
  assign use_idx = restart ? '0 : idx_q;

  always_comb begin
    idx_d = use_idx;
    if (advance) idx_d = IDX_W'(next_pos(32'(use_idx), PERIOD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/dither_thresh_cmp.sv
module dither_thresh_cmp #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned PERIOD = 4,
  parameter logic [PERIOD*PIX_W-1:0] TABLE = '0,
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [PIX_W-1:0] pix,
  output logic [PIX_W-1:0] thr,
  output logic             white,
  output logic [PIX_W-1:0] bin_pix
);
  import dither_pkg::*;

  logic [PIX_W-1:0] thr_arr [PERIOD];

  // Entry k sits at bits [k*PIX_W +: PIX_W] of TABLE.
  for (genvar k = 0; k < PERIOD; k++) begin : g_unpack
    assign thr_arr[k] = TABLE[k*PIX_W +: PIX_W];
  end

  assign thr     = thr_arr[idx];
  assign white   = is_above(32'(pix), 32'(thr));
  assign bin_pix = white ? '1 : '0;
endmodule

// File: rtl/dither_out_stage.sv
module dither_out_stage #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] load_pix,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             can_take
);
  // Register may refill in the cycle it is drained.
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pix   <= load_pix;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/halftone_dither.sv
module halftone_dither #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned PERIOD = 4,
  parameter logic [PERIOD*PIX_W-1:0] TABLE = {8'd96, 8'd224, 8'd160, 8'd32},
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  output logic             in_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  input  logic             out_ready
);
  // Named internal events used by the checker.
  logic             accept;
  logic [IDX_W-1:0] use_idx;
  logic [IDX_W-1:0] idx_q;
  logic [PIX_W-1:0] cur_thr;
  logic             cur_white;
  logic [PIX_W-1:0] cur_bin;

  assign accept = in_valid && in_ready;

  dither_index #(.PERIOD(PERIOD)) u_index (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept),
    .use_idx(use_idx), .idx_q(idx_q)
  );

  dither_thresh_cmp #(.PIX_W(PIX_W), .PERIOD(PERIOD), .TABLE(TABLE)) u_cmp (
    .idx(use_idx), .pix(in_pix), .thr(cur_thr), .white(cur_white), .bin_pix(cur_bin)
  );

  dither_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_pix(cur_bin),
    .out_ready(out_ready), .out_valid(out_valid), .out_pix(out_pix), .can_take(in_ready)
  );
endmodule

// File: rtl/halftone_dither_chk.sv
module halftone_dither_chk #(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned PERIOD = 4,
  localparam int unsigned IDX_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             restart,
  input logic             accept,
  input logic [IDX_W-1:0] idx_q,
  input logic             in_ready,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_ready
);
  assert_two_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pix == '0 || out_pix == '1));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < PERIOD);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !restart && 32'(idx_q) == PERIOD - 1 |=> idx_q == '0);

  assert_hold_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept && !restart |=> $stable(idx_q));

  assert_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart && !accept |=> idx_q == '0);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));

  assert_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind halftone_dither halftone_dither_chk #(.PIX_W(PIX_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .accept(accept), .idx_q(idx_q),
  .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix), .out_ready(out_ready)
);

// File: tb/halftone_dither_tb.sv
`timescale 1ns/1ps
module halftone_dither_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_pix;
  logic       out_ready = 1'b1;

  int n_cmp = 0;
  int n_bad = 0;
  int m_idx = 0;
  logic [7:0] exp_q[$];
  logic stall_prev = 1'b0;
  logic [7:0] pix_prev = '0;

  always #4 clk = ~clk;

  halftone_dither u_dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix), .out_ready(out_ready)
  );

  function automatic int thr_of(input int i);
    case (i)
      0: return 32;
      1: return 160;
      2: return 224;
      default: return 96;
    endcase
  endfunction

  function automatic logic [7:0] expect_pix(input int p, input int i);
    return (p > thr_of(i)) ? 8'd255 : 8'd0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step(input logic v, input logic [7:0] p, input logic r, input logic rs);
    logic fire_in, fire_out;
    int e;
    @(negedge clk);
    in_valid = v; in_pix = p; out_ready = r; restart = rs;
    #1;
    check("R7 out_valid", int'(out_valid), int'(exp_q.size() != 0));
    check("R9 R8 in_ready", int'(in_ready), int'(exp_q.size() == 0 || r));
    if (stall_prev) check("R8 held pix", int'(out_pix), int'(pix_prev));
    fire_out = out_valid && r;
    fire_in  = v && in_ready;
    if (fire_out && exp_q.size() != 0) begin
      check("R2 R3 R4 R6 out_pix", int'(out_pix), int'(exp_q[0]));
      void'(exp_q.pop_front());
    end
    stall_prev = out_valid && !r;
    pix_prev = out_pix;
    if (fire_in) begin
      e = rs ? 0 : m_idx;
      exp_q.push_back(expect_pix(int'(p), e));
      m_idx = (e + 1) % 4;
    end else if (rs) begin
      m_idx = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    // R1: first samples after reset use entry 0 onward
    for (int i = 0; i < 4; i++) step(1'b1, 8'(thr_of(i)), 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 8'(thr_of(i) + 1), 1'b1, 1'b0);
    step(1'b1, 8'd255, 1'b1, 1'b0);
    step(1'b1, 8'd0, 1'b1, 1'b0);
    // R5: idle cycles keep the position
    step(1'b0, 8'd200, 1'b1, 1'b0);
    step(1'b0, 8'd200, 1'b1, 1'b0);
    step(1'b1, 8'd225, 1'b1, 1'b0);
    // R8: stall with valid held
    for (int i = 0; i < 4; i++) step(1'b1, 8'd161, 1'b0, 1'b0);
    step(1'b1, 8'd161, 1'b1, 1'b0);
    // R6: restart alone, then restart with a sample
    step(1'b1, 8'd100, 1'b1, 1'b0);
    step(1'b0, 8'd0, 1'b1, 1'b1);
    step(1'b1, 8'd33, 1'b1, 1'b0);
    step(1'b1, 8'd161, 1'b1, 1'b0);
    step(1'b1, 8'd33, 1'b1, 1'b1);
    step(1'b1, 8'd160, 1'b1, 1'b0);
    // Random traffic with fixed seed
    void'($urandom(32'h1d17));
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 8'($urandom), ($urandom % 4) != 0, ($urandom % 40) == 0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'd0, 1'b1, 1'b0);
    check("R7 drained", exp_q.size(), 0);
    summary();
  end
endmodule